// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Pin Drive Mode

This block is a general-purpose I/O controller that sits behind an indexed configuration space. A front end, not part of this block, has already done any unlocking and device selection. It hands over an 8-bit register index, an 8-bit write value and a one-cycle write or read strobe. The pins are grouped into banks of at most eight. Each bank owns four consecutive register indices starting at its base:

- offset 0: direction
- offset 1: output latch
- offset 2: synchronized pin status
- offset 3: output drive style

Every pin feeds a pad model made of an output value and an output enable. The bench or the chip's pad ring resolves that pair into a tristate pad. A pin in push-pull style drives both levels. A pin in open-drain style can only pull low, and otherwise leaves the pad floating.

A small access sequencer serialises the strobes. It has three states:

- **ACC_IDLE** accepts a strobe. A write strobe takes the transition *IDLE→WRITE*. A read strobe takes *IDLE→READ*. If both strobes arrive together, the write wins.
- **ACC_WRITE** commits the held value into the addressed register, then takes *WRITE→IDLE*.
- **ACC_READ** captures the addressed register into the read-data output and raises a one-cycle valid flag, then takes *READ→IDLE*.

Strobes that arrive while the sequencer is in ACC_WRITE or ACC_READ are dropped. The number of banks, each bank's register base and each bank's pin count are parameters. The default has four banks: base 0xF0 with 8 pins, 0xE0 with 5 pins, 0xD0 with 7 pins and 0x88 with 4 pins. Each pin's pad pair sits at bit 8·bank + pin of the pad vectors.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Bank b decodes indices base_b+0 (direction), base_b+1 (output latch), base_b+2 (pin status) and base_b+3 (drive style). With the default parameters the bases are 0xF0, 0xE0, 0xD0 and 0x88. An index that hits no bank reads 0x00, and a write to it changes nothing.
- R2: A direction bit of 1 makes the pin an output. A direction bit of 0 makes it an input, and then its pad output enable is 0.
- R3: An output pin whose drive-style bit is 1 (push-pull) has its output enable at 1 and its pad value equal to its latch bit.
- R4: An output pin whose drive-style bit is 0 (open-drain) pulls the pad low (enable 1, value 0) when its latch bit is 0. It releases the pad (enable 0) when its latch bit is 1. Such a pin never drives a high level.
- R5: The status register returns each pad level through a two-flop synchronizer, for inputs and outputs alike. Writes to the status index are ignored.
- R6: After reset all direction, latch and drive-style bits are 0, every pad output enable is 0, and the read-valid flag is 0.
- R7: Bits above a bank's pin count read as 0 in every register of that bank. Writes to those bits have no effect, and their pads are never enabled.
- R8: Latch and drive-style values written while a pin is an input leave its pad released. They take effect on the pad in the same cycle that the direction bit becomes 1.
- R9: A write strobe sampled at clock edge k updates the register at edge k+1. A read strobe sampled at edge k places the data on the read-data output, with the valid flag high for exactly one cycle, at edge k+1. Strobes sampled while the sequencer is in ACC_WRITE or ACC_READ are dropped. A simultaneous write and read strobe performs only the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_index | input | 8 | Register index of the access |
| cfg_wdata | input | 8 | Write value |
| cfg_wr | input | 1 | One-cycle write strobe |
| cfg_rd | input | 1 | One-cycle read strobe |
| cfg_rdata | output | 8 | Captured read value |
| cfg_rvalid | output | 1 | One-cycle flag marking cfg_rdata as new |
| pad_in | input | 8·NUM_BANKS | Resolved pad levels, bank b at bits 8b+7..8b |
| pad_out | output | 8·NUM_BANKS | Value driven onto each pad |
| pad_oe | output | 8·NUM_BANKS | Output enable of each pad |

## Verification
The hardest situation to reach from the ports is a pad whose enable stays 0 even though its latch and drive style already hold "drive". That state exists only between a latch write and the later direction write. The stimulus stages it deliberately: it programs the drive style and the latch of a bank whose pins are all inputs, checks that the pad bank is still released, and then sets a single direction bit. After that it checks that exactly that pad comes up carrying the preset level. A second case that is hard to reach is a strobe that lands while the sequencer is busy. The bench creates it by holding the write strobe for two consecutive cycles with different data, and by raising read and write together. It then proves through a readback that only the first write landed and that no read response appeared.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;

    localparam int PINS_PER_BANK = 8;
    localparam int REGS_PER_BANK = 4;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_state_e;

    typedef enum logic [1:0] {
        SEL_DIR    = 2'd0,
        SEL_LATCH  = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_STYLE  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_access_fsm.sv
module gpio_access_fsm
    import gpio_cfg_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr,
    input  logic              req_rd,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [DATA_W-1:0] req_data,
    output logic [IDX_W-1:0]  held_index,
    output logic [DATA_W-1:0] held_data,
    output logic              commit_wr,
    output logic              capture_rd
);

    acc_state_e state_q;
    acc_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: begin
                if (req_wr) begin
                    state_d = ACC_WRITE;
                end else if (req_rd) begin
                    state_d = ACC_READ;
                end
            end
            ACC_WRITE: state_d = ACC_IDLE;
            ACC_READ:  state_d = ACC_IDLE;
            default:   state_d = ACC_IDLE;
        endcase
    end

    // request holding register, loaded only when a strobe is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_index <= '0;
            held_data  <= '0;
        end else if (state_q == ACC_IDLE && (req_wr || req_rd)) begin
            held_index <= req_index;
            held_data  <= req_data;
        end
    end

    // outputs
    always_comb begin
        commit_wr  = 1'b0;
        capture_rd = 1'b0;
        unique case (state_q)
            ACC_IDLE:  ;
            ACC_WRITE: commit_wr  = 1'b1;
            ACC_READ:  capture_rd = 1'b1;
            default:   ;
        endcase
    end

    // R9: a busy state lasts one cycle
    p_busy_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ACC_IDLE) |=> (state_q == ACC_IDLE));

    // R9: strobes during a busy state do not disturb the held request
    p_busy_holds_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ACC_IDLE) |=> ($stable(held_index) && $stable(held_data)));

    // R9: write wins over a simultaneous read
    p_write_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACC_IDLE && req_wr && req_rd) |=> (state_q == ACC_WRITE));

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_cfg_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [1:0]               reg_sel,
    input  logic [PINS_PER_BANK-1:0] wdata,
    output logic [PINS_PER_BANK-1:0] rd_data,
    input  logic [PINS_PER_BANK-1:0] pad_in,
    output logic [PINS_PER_BANK-1:0] pad_out,
    output logic [PINS_PER_BANK-1:0] pad_oe
);

    localparam logic [PINS_PER_BANK:0]   MASK_WIDE = (({{PINS_PER_BANK{1'b0}}, 1'b1}) << PINS) - 1'b1;
    localparam logic [PINS_PER_BANK-1:0] PIN_MASK  = MASK_WIDE[PINS_PER_BANK-1:0];

    logic [PINS_PER_BANK-1:0] dir_q;
    logic [PINS_PER_BANK-1:0] latch_q;
    logic [PINS_PER_BANK-1:0] style_q;
    logic [PINS_PER_BANK-1:0] sync1_q;
    logic [PINS_PER_BANK-1:0] status_q;
    logic [1:0]               warm_q;

    // control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            latch_q <= '0;
            style_q <= '0;
        end else if (wr_en) begin
            unique case (reg_sel_e'(reg_sel))
                SEL_DIR:    dir_q   <= wdata & PIN_MASK;
                SEL_LATCH:  latch_q <= wdata & PIN_MASK;
                SEL_STATUS: ;
                SEL_STYLE:  style_q <= wdata & PIN_MASK;
                default:    ;
            endcase
        end
    end

    // two-flop synchronizer on the pad levels
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q  <= '0;
            status_q <= '0;
        end else begin
            sync1_q  <= pad_in & PIN_MASK;
            status_q <= sync1_q;
        end
    end

    // read selection
    always_comb begin
        rd_data = '0;
        unique case (reg_sel_e'(reg_sel))
            SEL_DIR:    rd_data = dir_q;
            SEL_LATCH:  rd_data = latch_q;
            SEL_STATUS: rd_data = status_q;
            SEL_STYLE:  rd_data = style_q;
            default:    rd_data = '0;
        endcase
    end

    // per-pin pad drivers
    for (genvar p = 0; p < PINS_PER_BANK; p++) begin : g_pin
        if (p < PINS) begin : g_live
            always_comb begin
                if (!dir_q[p]) begin
                    pad_oe[p]  = 1'b0;
                    pad_out[p] = 1'b0;
                end else if (style_q[p]) begin
                    pad_oe[p]  = 1'b1;
                    pad_out[p] = latch_q[p];
                end else begin
                    pad_oe[p]  = ~latch_q[p];
                    pad_out[p] = 1'b0;
                end
            end
        end else begin : g_absent
            assign pad_oe[p]  = 1'b0;
            assign pad_out[p] = 1'b0;
        end
    end

    // cycles since reset, saturating, used to qualify the synchronizer check
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R5: status is the pad level delayed by two edges
    p_status_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (status_q == ($past(pad_in, 2) & PIN_MASK)));

    // R4: an open-drain pin never drives a high level
    p_od_no_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & pad_out & ~style_q) == '0));

    // R7: missing pins never enable their pad
    p_absent_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~PIN_MASK) == '0));

    // R9: registers move only on a committed write
    p_regs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(dir_q) && $stable(latch_q) && $stable(style_q)));

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_cfg_pkg::*;
#(
    parameter int                    NUM_BANKS       = 4,
    parameter logic [8*NUM_BANKS-1:0] BANK_BASES     = {8'h88, 8'hD0, 8'hE0, 8'hF0},
    parameter logic [4*NUM_BANKS-1:0] BANK_PIN_COUNT = {4'd4, 4'd7, 4'd5, 4'd8},
    localparam int                   PAD_W           = PINS_PER_BANK * NUM_BANKS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       cfg_index,
    input  logic [7:0]       cfg_wdata,
    input  logic             cfg_wr,
    input  logic             cfg_rd,
    output logic [7:0]       cfg_rdata,
    output logic             cfg_rvalid,
    input  logic [PAD_W-1:0] pad_in,
    output logic [PAD_W-1:0] pad_out,
    output logic [PAD_W-1:0] pad_oe
);

    logic [7:0]     held_index;
    logic [7:0]     held_data;
    logic           commit_wr;
    logic           capture_rd;
    logic [NUM_BANKS-1:0] bank_hit;
    logic [7:0]     bank_rd [NUM_BANKS];
    logic [7:0]     rd_mux;

    gpio_access_fsm #(
        .IDX_W  (8),
        .DATA_W (8)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_wr     (cfg_wr),
        .req_rd     (cfg_rd),
        .req_index  (cfg_index),
        .req_data   (cfg_wdata),
        .held_index (held_index),
        .held_data  (held_data),
        .commit_wr  (commit_wr),
        .capture_rd (capture_rd)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [7:0] BASE = BANK_BASES[8*b +: 8];
        localparam int         PINS = int'(BANK_PIN_COUNT[4*b +: 4]);

        assign bank_hit[b] = (held_index[7:2] == BASE[7:2]);

        gpio_bank #(
            .PINS (PINS)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (commit_wr && bank_hit[b]),
            .reg_sel (held_index[1:0]),
            .wdata   (held_data),
            .rd_data (bank_rd[b]),
            .pad_in  (pad_in[8*b +: 8]),
            .pad_out (pad_out[8*b +: 8]),
            .pad_oe  (pad_oe[8*b +: 8])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) begin
                rd_mux = rd_mux | bank_rd[b];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_rdata  <= '0;
            cfg_rvalid <= 1'b0;
        end else begin
            cfg_rvalid <= capture_rd;
            if (capture_rd) begin
                cfg_rdata <= rd_mux;
            end
        end
    end

    // R9: read-valid is a single-cycle pulse
    p_rvalid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rvalid |=> !cfg_rvalid);

    // R9: a write strobe accepted from idle never yields read data
    p_write_no_response_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_wr |=> !cfg_rvalid);

    // R6: pads are released while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_released_r6: assert (pad_oe == '0);
        end
    end

endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;

    localparam int PAD_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       cfg_index = '0;
    logic [7:0]       cfg_wdata = '0;
    logic             cfg_wr = 1'b0;
    logic             cfg_rd = 1'b0;
    logic [7:0]       cfg_rdata;
    logic             cfg_rvalid;
    logic [PAD_W-1:0] pad_in;
    logic [PAD_W-1:0] pad_out;
    logic [PAD_W-1:0] pad_oe;
    logic [PAD_W-1:0] ext_level = '1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // pad resolution: driven value where enabled, external pull elsewhere
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_level);

    gpio_bank_ctrl u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_index  (cfg_index),
        .cfg_wdata  (cfg_wdata),
        .cfg_wr     (cfg_wr),
        .cfg_rd     (cfg_rd),
        .cfg_rdata  (cfg_rdata),
        .cfg_rvalid (cfg_rvalid),
        .pad_in     (pad_in),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    // {index, write value, expected readback}
    localparam logic [23:0] VEC [10] = '{
        {8'hF1, 8'hA5, 8'hA5},   // R1 latch of bank 0
        {8'hF3, 8'h3C, 8'h3C},   // R1 style of bank 0
        {8'hF0, 8'h0F, 8'h0F},   // R1 direction of bank 0
        {8'hE1, 8'hFF, 8'h1F},   // R7 five-pin bank masks latch
        {8'hE3, 8'hAA, 8'h0A},   // R7 five-pin bank masks style
        {8'hD0, 8'hFF, 8'h7F},   // R7 seven-pin bank masks direction
        {8'h8B, 8'hFF, 8'h0F},   // R1 odd base 0x88, four pins
        {8'h8C, 8'h55, 8'h00},   // R1 unmapped index reads zero
        {8'hE0, 8'hE0, 8'h00},   // R7 only unimplemented bits written
        {8'hD1, 8'h80, 8'h00}    // R7 bit 7 of seven-pin bank
    };

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] idx, input logic [7:0] val);
        @(negedge clk);
        cfg_index = idx;
        cfg_wdata = val;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [7:0] idx, output logic [7:0] val, output logic vld);
        @(negedge clk);
        cfg_index = idx;
        cfg_rd = 1'b1;
        @(negedge clk);
        cfg_rd = 1'b0;
        @(negedge clk);
        val = cfg_rdata;
        vld = cfg_rvalid;
    endtask

    // expected pad pair of one bank from requirement R2-R4
    function automatic logic [15:0] pad_model(input logic [7:0] d, input logic [7:0] l, input logic [7:0] s);
        logic [7:0] oe;
        logic [7:0] o;
        oe = d & (s | ~l);
        o  = d & s & l;
        return {oe, o};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        logic       vl;
        logic [15:0] pm;

        repeat (3) @(negedge clk);
        // R6: reset state
        check8("R6 pad_oe low byte during reset", pad_oe[7:0], 8'h00);
        check8("R6 rvalid during reset", {7'd0, cfg_rvalid}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check8("R6 pad_oe after reset", pad_oe[31:24] | pad_oe[23:16] | pad_oe[15:8] | pad_oe[7:0], 8'h00);
        do_read(8'hF0, rv, vl);
        check8("R6 direction reset", rv, 8'h00);
        check8("R9 rvalid raised two edges after read strobe", {7'd0, vl}, 8'h01);
        @(negedge clk);
        check8("R9 rvalid is one cycle", {7'd0, cfg_rvalid}, 8'h00);
        do_read(8'hF1, rv, vl);
        check8("R6 latch reset", rv, 8'h00);
        do_read(8'hD3, rv, vl);
        check8("R6 style reset", rv, 8'h00);

        // table: write then read back
        for (int i = 0; i < 10; i++) begin
            do_write(VEC[i][23:16], VEC[i][15:8]);
            do_read(VEC[i][23:16], rv, vl);
            check8($sformatf("R1/R7 vector %0d index %02h", i, VEC[i][23:16]), rv, VEC[i][7:0]);
        end

        // R3/R4: bank 0 dir 0F latch A5 style 3C
        pm = pad_model(8'h0F, 8'hA5, 8'h3C);
        check8("R3/R4 bank0 pad_oe", pad_oe[7:0], pm[15:8]);
        check8("R3 bank0 pad_out", pad_out[7:0], pm[7:0]);
        check8("R3 bank0 pad_oe literal", pad_oe[7:0], 8'h0E);
        check8("R4 bank2 open-drain pulls low", pad_oe[23:16], 8'h7F);
        check8("R4 bank2 never high", pad_out[23:16], 8'h00);
        check8("R2 bank1 inputs released", pad_oe[15:8], 8'h00);
        check8("R7 bank3 pads released", pad_oe[31:24], 8'h00);

        // R5: status with external pull-ups
        repeat (3) @(negedge clk);
        do_read(8'hF2, rv, vl);
        check8("R5 bank0 status mixes driven and pulled", rv, 8'hF5);
        do_read(8'hD2, rv, vl);
        check8("R5 bank2 status of driven-low outputs", rv, 8'h00);
        do_read(8'hE2, rv, vl);
        check8("R5/R7 bank1 status masked", rv, 8'h1F);
        ext_level[15:8] = 8'h00;
        repeat (3) @(negedge clk);
        do_read(8'hE2, rv, vl);
        check8("R5 bank1 status follows pad", rv, 8'h00);
        do_write(8'hE2, 8'hFF);
        do_read(8'hE2, rv, vl);
        check8("R5 status write ignored", rv, 8'h00);
        ext_level[15:8] = 8'hFF;
        do_read(8'h8A, rv, vl);
        check8("R7 bank3 status masked", rv, 8'h0F);

        // R8: preset while input, then enable one pin
        do_write(8'hD0, 8'h00);
        do_write(8'hD3, 8'hFF);
        do_write(8'hD1, 8'h55);
        check8("R8 preset keeps pads released", pad_oe[23:16], 8'h00);
        do_write(8'hD0, 8'h01);
        check8("R8 enabled pin drives preset", pad_oe[23:16], 8'h01);
        check8("R8 enabled pin level", pad_out[23:16], 8'h01);

        // R2: back to inputs
        do_write(8'hF0, 8'h00);
        check8("R2 direction 0 releases bank0", pad_oe[7:0], 8'h00);

        // R9: second write strobe while busy is dropped
        @(negedge clk);
        cfg_index = 8'hF1;
        cfg_wdata = 8'h00;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wdata = 8'hFF;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
        do_read(8'hF1, rv, vl);
        check8("R9 busy write dropped", rv, 8'h00);

        // R9: simultaneous write and read performs only the write
        @(negedge clk);
        cfg_index = 8'hF3;
        cfg_wdata = 8'h11;
        cfg_wr = 1'b1;
        cfg_rd = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        cfg_rd = 1'b0;
        @(negedge clk);
        check8("R9 no read response on combined strobe", {7'd0, cfg_rvalid}, 8'h00);
        do_read(8'hF3, rv, vl);
        check8("R9 combined strobe wrote", rv, 8'h11);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule